// File: doc/BRIEF.md
# Multi-function Integer ALU

This block is a clocked integer arithmetic-logic unit of 32 bits. A one-cycle `in_valid` pulse marks when the two operands and a 4-bit operation code are present. One clock later the unit presents its answer: a 32-bit result, an overflow flag and a one-cycle `out_valid` pulse. The result and flag are registered, and they keep their value until the next accepted operation.

Each arithmetic operation (add, subtract, multiply) has a signed form and an unsigned form, and each form has its own overflow rule. Max and min come in both forms too. The logical group covers AND, OR, XOR, inversion of A and bit reversal of A. When an arithmetic result does not fit, the low 32 bits of the true result are returned and the flag is raised. Reset is asynchronous and active low.

Top module: `int_alu`

## Requirements
- R1: Codes 0, 1 and 2 give signed A+B, A-B and A*B as the low 32 bits of the exact result. The overflow flag is 1 exactly when the exact two's-complement result lies outside [-2^31, 2^31-1].
- R2: Codes 5, 6 and 7 give unsigned A+B, A-B and A*B as the low 32 bits of the exact result. Overflow is set on a carry out of bit 31 for add, when B > A for subtract, and when the 64-bit product has any bit set in bits 63..32 for multiply.
- R3: Code 3 gives the signed maximum and code 4 the signed minimum. Code 8 gives the unsigned maximum and code 9 the unsigned minimum.
- R4: Code 10 gives A AND B, code 11 gives A OR B, and code 12 gives A XOR B.
- R5: Code 13 gives the bitwise inverse of A. Code 14 gives A with bit i moved to bit 31-i. B has no effect on either.
- R6: Code 15 gives a result of 0. The overflow flag is 0 for codes 3, 4 and 8 to 15.
- R7: `out_valid` is high for exactly the one cycle after each cycle in which `in_valid` is high. In that cycle the result and the flag belong to that request.
- R8: While no request is accepted, the result and the flag keep their last value.
- R9: Driving `rst_n` low clears `result`, `ovf` and `out_valid` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One-cycle pulse qualifying the operands and the code |
| op_code | input | 4 | Operation select |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered overflow flag |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that the operands and the code are only meaningful in cycles where `in_valid` is high. They also assume that a request may arrive in any cycle, including back to back. The bench drives `in_valid` for a single cycle at a time and leaves idle gaps, so that the hold behaviour can be seen between requests. Random operands come from a fixed seed, and the operation code is drawn across the full 4-bit range. Directed vectors sit on the signed and unsigned wrap boundaries and on the B > A borrow case.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         out_valid
);
  localparam int W2 = 2 * W;

  localparam logic [3:0] OP_SADD = 4'd0,  OP_SSUB = 4'd1,  OP_SMUL = 4'd2,
                         OP_SMAX = 4'd3,  OP_SMIN = 4'd4,  OP_UADD = 4'd5,
                         OP_USUB = 4'd6,  OP_UMUL = 4'd7,  OP_UMAX = 4'd8,
                         OP_UMIN = 4'd9,  OP_AND  = 4'd10, OP_OR   = 4'd11,
                         OP_XOR  = 4'd12, OP_INV  = 4'd13, OP_REV  = 4'd14;

  logic [W:0]    sum_x, dif_x;
  logic [W2-1:0] sprod, uprod;
  logic [W-1:0]  rev_a;
  logic          s_lt, u_lt, sa, sb;
  logic [W-1:0]  nxt_res;
  logic          nxt_ovf;

  assign sa    = op_a[W-1];
  assign sb    = op_b[W-1];
  assign sum_x = {1'b0, op_a} + {1'b0, op_b};
  assign dif_x = {1'b0, op_a} - {1'b0, op_b};
  assign sprod = $signed({{W{sa}}, op_a}) * $signed({{W{sb}}, op_b});
  assign uprod = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
  assign s_lt  = $signed(op_a) < $signed(op_b);
  assign u_lt  = op_a < op_b;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_a[i] = op_a[W-1-i];
  end

  always_comb begin
    nxt_res = '0;
    nxt_ovf = 1'b0;
    case (op_code)
      OP_SADD: begin
        nxt_res = sum_x[W-1:0];
        nxt_ovf = (sa == sb) && (sum_x[W-1] != sa);
      end
      OP_SSUB: begin
        nxt_res = dif_x[W-1:0];
        nxt_ovf = (sa != sb) && (dif_x[W-1] != sa);
      end
      OP_SMUL: begin
        nxt_res = sprod[W-1:0];
        nxt_ovf = !((&sprod[W2-1:W-1]) || !(|sprod[W2-1:W-1]));
      end
      OP_SMAX: nxt_res = s_lt ? op_b : op_a;
      OP_SMIN: nxt_res = s_lt ? op_a : op_b;
      OP_UADD: begin
        nxt_res = sum_x[W-1:0];
        nxt_ovf = sum_x[W];
      end
      OP_USUB: begin
        nxt_res = dif_x[W-1:0];
        nxt_ovf = dif_x[W];
      end
      OP_UMUL: begin
        nxt_res = uprod[W-1:0];
        nxt_ovf = |uprod[W2-1:W];
      end
      OP_UMAX: nxt_res = u_lt ? op_b : op_a;
      OP_UMIN: nxt_res = u_lt ? op_a : op_b;
      OP_AND:  nxt_res = op_a & op_b;
      OP_OR:   nxt_res = op_a | op_b;
      OP_XOR:  nxt_res = op_a ^ op_b;
      OP_INV:  nxt_res = ~op_a;
      OP_REV:  nxt_res = rev_a;
      default: nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      ovf       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        ovf    <= nxt_ovf;
      end
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] result,
  input logic         ovf,
  input logic         out_valid
);
  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ovf)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_code == 4'd3 || op_code == 4'd4 || op_code >= 4'd8)) |=> !ovf);

  // R6
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd15) |=> (result == '0));

  // R5
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd13) |=> (result == ~$past(op_a)));

  // R2
  borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd6) |=> (ovf == ($past(op_b) > $past(op_a))));
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .op_a(op_a), .op_b(op_b), .result(result), .ovf(ovf), .out_valid(out_valid)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] result;
  logic        ovf, out_valid;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] last_res;
  logic        last_ovf;

  always #5 clk = ~clk;

  int_alu u_int_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .result(result), .ovf(ovf), .out_valid(out_valid)
  );

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] sa, sb, za, zb, t;
    logic [31:0] r;
    logic        o;
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    za = {32'd0, a};       zb = {32'd0, b};
    r = '0; o = 1'b0;
    case (op)
      4'd0: begin t = sa + sb; r = t[31:0]; o = !(t[63:31] == '0 || t[63:31] == '1); end
      4'd1: begin t = sa - sb; r = t[31:0]; o = !(t[63:31] == '0 || t[63:31] == '1); end
      4'd2: begin t = sa * sb; r = t[31:0]; o = !(t[63:31] == '0 || t[63:31] == '1); end
      4'd3: r = ($signed(a) > $signed(b)) ? a : b;
      4'd4: r = ($signed(a) > $signed(b)) ? b : a;
      4'd5: begin t = za + zb; r = t[31:0]; o = t > 64'hFFFF_FFFF; end
      4'd6: begin r = a - b; o = b > a; end
      4'd7: begin t = za * zb; r = t[31:0]; o = t > 64'hFFFF_FFFF; end
      4'd8: r = (a > b) ? a : b;
      4'd9: r = (a > b) ? b : a;
      4'd10: r = a & b;
      4'd11: r = a | b;
      4'd12: r = a ^ b;
      4'd13: r = ~a;
      4'd14: for (int i = 0; i < 32; i++) r[31-i] = a[i];
      default: r = '0;
    endcase
    return {o, r};
  endfunction

  function automatic string tag(input logic [3:0] op);
    if (op <= 4'd2) return "R1";
    if (op == 4'd5 || op == 4'd6 || op == 4'd7) return "R2";
    if (op == 4'd3 || op == 4'd4 || op == 4'd8 || op == 4'd9) return "R3";
    if (op <= 4'd12) return "R4";
    if (op <= 4'd14) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input bit gap);
    logic [32:0] e;
    e = model(op, a, b);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0; op_a = $urandom; op_b = $urandom; op_code = 4'($urandom);
    // R7: pulse and data one cycle after the request
    check("R7", {1'b0, out_valid, 32'd0}, {1'b0, 1'b1, 32'd0});
    check(tag(op), {1'b0, ovf, result}, {1'b0, e});
    last_res = result; last_ovf = ovf;
    if (gap) begin
      @(negedge clk);
      // R7 and R8: no pulse, and the outputs hold while inputs wander
      check("R7", {1'b0, out_valid, 32'd0}, 34'd0);
      check("R8", {1'b0, ovf, result}, {1'b0, last_ovf, last_res});
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    // R9: reset state
    check("R9", {1'b0, out_valid, 32'd0}, 34'd0);
    check("R9", {1'b0, ovf, result}, 34'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 corners
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);
    apply(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1);
    apply(4'd1, 32'h8000_0000, 32'd1, 1'b0);
    apply(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply(4'd1, 32'd5, 32'd9, 1'b0);
    apply(4'd2, 32'h0001_0000, 32'h0000_8000, 1'b1);
    apply(4'd2, 32'hFFFF_0000, 32'h0000_8000, 1'b0);
    apply(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    apply(4'd2, 32'hFFFF_FFFD, 32'd7, 1'b0);
    // R2 corners
    apply(4'd5, 32'hFFFF_FFFF, 32'd1, 1'b1);
    apply(4'd5, 32'hFFFF_FFFE, 32'd1, 1'b0);
    apply(4'd6, 32'd3, 32'd4, 1'b1);
    apply(4'd6, 32'd4, 32'd4, 1'b0);
    apply(4'd7, 32'h0001_0000, 32'h0001_0000, 1'b1);
    apply(4'd7, 32'h0000_FFFF, 32'h0001_0001, 1'b0);
    // R3 signed vs unsigned ordering
    apply(4'd3, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply(4'd4, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply(4'd8, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply(4'd9, 32'hFFFF_FFFF, 32'd1, 1'b1);
    // R4, R5, R6 directed
    apply(4'd10, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0);
    apply(4'd11, 32'hF0F0_1234, 32'h0FF0_0000, 1'b0);
    apply(4'd12, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1);
    apply(4'd13, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0);
    apply(4'd13, 32'h1234_5678, 32'h0000_0000, 1'b0);
    apply(4'd14, 32'h0000_0001, 32'hDEAD_BEEF, 1'b0);
    apply(4'd14, 32'h1234_5678, 32'h0, 1'b1);
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

    // random mix across all codes
    for (int k = 0; k < 600; k++)
      apply(4'($urandom), $urandom, $urandom, 1'($urandom));

    // R9: asynchronous clear mid-cycle
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0);
    #2 rst_n = 1'b0;
    #1;
    check("R9", {1'b0, out_valid, 32'd0}, 34'd0);
    check("R9", {1'b0, ovf, result}, 34'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule